// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps a DRAM array alive by issuing refresh cycles at an average rate that covers every row within the retention period. A free-running interval timer adds one owed refresh to a small backlog counter each time it expires. Whenever the backlog is non-zero and no refresh is running, the block raises a request to the access controller. Once that controller grants, the block takes over the strobes, runs one refresh cycle and then pays one refresh off the backlog.

A parameter selects one of two refresh methods. In CAS-before-RAS mode, the column strobe falls before the row strobe, and the device picks the row from its own internal counter. In RAS-only mode, the column strobe stays high, and the block presents the row address from its own wrapping row counter. In both modes the write enable stays high, and an active flag tells the controller to float the data bus. When the backlog is full, an urgent flag asks the controller to grant ahead of normal traffic. Holding the grant high lets the block drain owed refreshes back to back.

Top module: `dram_refresh_sched`

## Requirements
- R1: During and after reset, ras_n, cas_n and we_n are 1, ref_req, ref_urgent and ref_active are 0, backlog is 0 and row_addr is 0.
- R2: The backlog rises by one at the end of every TICK_CYCLES-th clock after reset, provided no refresh completes in that clock. TICK_CYCLES defaults to clock kHz times retention ms divided by the refresh count.
- R3: The backlog never exceeds BACKLOG_MAX, and further timer expiries while it is full are dropped. ref_urgent is 1 exactly when backlog equals BACKLOG_MAX.
- R4: ref_req is 1 exactly when the block is idle and backlog is non-zero. If ref_grant is 1 while ref_req is 1, a refresh starts at the next clock. ref_grant has no effect while backlog is 0.
- R5: In CAS-before-RAS mode (RAS_ONLY=0), the refresh is laid out in three phases. First, cas_n is 0 with ras_n at 1 for CAS_LEAD_CYCLES clocks. Next, ras_n and cas_n are both 0 for RAS_LOW_CYCLES clocks. Last, both are 1 for PRECHARGE_CYCLES clocks.
- R6: In RAS-only mode (RAS_ONLY=1), ras_n is 0 for RAS_LOW_CYCLES clocks and then 1 for PRECHARGE_CYCLES clocks, and cas_n stays 1 throughout.
- R7: we_n is always 1. ref_active is 1 for every clock of a refresh sequence, including precharge, and 0 otherwise, so that the data bus is left floating.
- R8: In RAS-only mode, row_addr stays steady while ras_n is 0 and advances by one, modulo 2^ROW_BITS, when each refresh completes. In CAS-before-RAS mode, row_addr stays 0.
- R9: Each completed refresh lowers the backlog by one at the clock that ends precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_grant | input | 1 | Access controller hands the strobes to refresh |
| ref_req | output | 1 | Refresh owed and block idle |
| ref_urgent | output | 1 | Backlog full |
| ref_active | output | 1 | Refresh sequence owns the strobes; data bus must float |
| backlog | output | $clog2(BACKLOG_MAX+1) | Number of owed refreshes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| row_addr | output | ROW_BITS | Row presented in RAS-only mode |

## Verification
A timer expiry shows up on backlog in the clock in which it happens. The bench therefore counts clock edges from reset release and predicts the backlog as edges divided by TICK_CYCLES, capped at the maximum, sampling at each falling edge. A grant given before edge k changes the strobes right after edge k. The bench walks the sequence one clock at a time from that edge, and the backlog drop is checked one clock after the last precharge clock. Grants are placed just after a timer expiry, so no tick falls inside the window being checked. During back-to-back draining, each new refresh is checked to start one clock after the backlog turns non-zero, and the row is checked at every falling edge of the row strobe.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int CLK_KHZ          = 125000,
  parameter int RETENTION_MS     = 64,
  parameter int REFRESH_COUNT    = 4096,
  parameter int TICK_CYCLES      = (CLK_KHZ * RETENTION_MS) / REFRESH_COUNT,
  parameter int ROW_BITS         = 12,
  parameter int BACKLOG_MAX      = 8,
  parameter int CAS_LEAD_CYCLES  = 1,
  parameter int RAS_LOW_CYCLES   = 4,
  parameter int PRECHARGE_CYCLES = 3,
  parameter bit RAS_ONLY         = 1'b0
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               ref_grant,
  output logic                               ref_req,
  output logic                               ref_urgent,
  output logic                               ref_active,
  output logic [$clog2(BACKLOG_MAX+1)-1:0]   backlog,
  output logic                               ras_n,
  output logic                               cas_n,
  output logic                               we_n,
  output logic [ROW_BITS-1:0]                row_addr
);
  localparam int TW    = $clog2(TICK_CYCLES + 1);
  localparam int BW    = $clog2(BACKLOG_MAX + 1);
  localparam int MAXA  = (CAS_LEAD_CYCLES > RAS_LOW_CYCLES) ? CAS_LEAD_CYCLES : RAS_LOW_CYCLES;
  localparam int MAXPH = (MAXA > PRECHARGE_CYCLES) ? MAXA : PRECHARGE_CYCLES;
  localparam int PW    = $clog2(MAXPH + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_RAS, ST_PRE} state_t;

  state_t              state;
  logic [PW-1:0]       ph;
  logic [TW-1:0]       tmr;
  logic [ROW_BITS-1:0] row;
  logic                tick, full, done, inc;

  assign tick = (tmr == TW'(TICK_CYCLES - 1));
  assign full = (backlog == BW'(BACKLOG_MAX));
  assign done = (state == ST_PRE) && (ph == '0);
  assign inc  = tick && (!full || done);

  assign ref_req    = (state == ST_IDLE) && (backlog != '0);
  assign ref_urgent = full;
  assign ref_active = (state != ST_IDLE);
  assign ras_n      = (state != ST_RAS);
  assign cas_n      = RAS_ONLY ? 1'b1 : !((state == ST_LEAD) || (state == ST_RAS));
  assign we_n       = 1'b1;
  assign row_addr   = row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr     <= '0;
      backlog <= '0;
      state   <= ST_IDLE;
      ph      <= '0;
      row     <= '0;
    end else begin
      tmr <= tick ? '0 : tmr + 1'b1;
      if (inc && !done)      backlog <= backlog + 1'b1;
      else if (done && !inc) backlog <= backlog - 1'b1;
      case (state)
        ST_IDLE: if (ref_req && ref_grant) begin
          if (RAS_ONLY) begin
            state <= ST_RAS;
            ph    <= PW'(RAS_LOW_CYCLES - 1);
          end else begin
            state <= ST_LEAD;
            ph    <= PW'(CAS_LEAD_CYCLES - 1);
          end
        end
        ST_LEAD: if (ph == '0) begin
          state <= ST_RAS;
          ph    <= PW'(RAS_LOW_CYCLES - 1);
        end else ph <= ph - 1'b1;
        ST_RAS: if (ph == '0) begin
          state <= ST_PRE;
          ph    <= PW'(PRECHARGE_CYCLES - 1);
        end else ph <= ph - 1'b1;
        default: if (ph == '0) begin
          state <= ST_IDLE;
          if (RAS_ONLY) row <= row + 1'b1;
        end else ph <= ph - 1'b1;
      endcase
    end
  end

  assert_backlog_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    backlog <= BW'(BACKLOG_MAX));
  assert_no_start_when_owed_none_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_active && backlog == '0) |=> !ref_active);
  assert_strobes_inside_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> ref_active);
  assert_urgent_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_urgent && !ref_active) |-> ref_req);

  generate
    if (RAS_ONLY) begin : g_ro_chk
      assert_cas_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> cas_n);
      assert_row_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |=> (ras_n || $stable(row_addr)));
    end else begin : g_cbr_chk
      assert_cas_before_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
      assert_row_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        row_addr == '0);
    end
  endgenerate
endmodule

// File: tb/dram_refresh_sched_tb.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb_top;
  localparam int TICK = 40, MAXB = 4, ROWB = 3, LEAD = 1, RASL = 3, PRE = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic g_c = 1'b0, g_r = 1'b0;
  logic req_c, urg_c, act_c, ras_c, cas_c, we_c;
  logic req_r, urg_r, act_r, ras_r, cas_r, we_r;
  logic [2:0] bl_c, bl_r;
  logic [ROWB-1:0] row_c, row_r;
  int tests = 0, fails = 0, edges = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) if (rst_n) edges <= edges + 1;

  dram_refresh_sched #(.TICK_CYCLES(TICK), .ROW_BITS(ROWB), .BACKLOG_MAX(MAXB),
    .CAS_LEAD_CYCLES(LEAD), .RAS_LOW_CYCLES(RASL), .PRECHARGE_CYCLES(PRE), .RAS_ONLY(1'b0))
  dut_i (.clk(clk), .rst_n(rst_n), .ref_grant(g_c), .ref_req(req_c), .ref_urgent(urg_c),
    .ref_active(act_c), .backlog(bl_c), .ras_n(ras_c), .cas_n(cas_c), .we_n(we_c), .row_addr(row_c));

  dram_refresh_sched #(.TICK_CYCLES(TICK), .ROW_BITS(ROWB), .BACKLOG_MAX(MAXB),
    .CAS_LEAD_CYCLES(LEAD), .RAS_LOW_CYCLES(RASL), .PRECHARGE_CYCLES(PRE), .RAS_ONLY(1'b1))
  dut_ro_i (.clk(clk), .rst_n(rst_n), .ref_grant(g_r), .ref_req(req_r), .ref_urgent(urg_r),
    .ref_active(act_r), .backlog(bl_r), .ras_n(ras_r), .cas_n(cas_r), .we_n(we_r), .row_addr(row_r));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int exp, k, prev_ras, prev_bl, prev_act;
    repeat (3) @(negedge clk);
    chk("R1 ras_n", ras_c & ras_r, 1);  chk("R1 cas_n", cas_c & cas_r, 1);
    chk("R1 we_n", we_c & we_r, 1);     chk("R1 req", req_c | req_r, 0);
    chk("R1 urgent", urg_c | urg_r, 0); chk("R1 active", act_c | act_r, 0);
    chk("R1 backlog", bl_c + bl_r, 0);  chk("R1 row", row_r, 0);
    rst_n = 1'b1;
    for (int n = 1; n <= TICK * (MAXB + 2); n++) begin
      @(posedge clk); @(negedge clk);
      exp = (n / TICK > MAXB) ? MAXB : n / TICK;
      chk("R2 backlog cbr", bl_c, exp);
      chk("R2 backlog ro", bl_r, exp);
      chk("R4 req", req_c, int'(exp != 0));
      chk("R3 urgent", urg_r, int'(exp == MAXB));
    end
    while (edges % TICK != 1) @(negedge clk);
    g_c = 1'b1; g_r = 1'b1;
    for (int i = 1; i <= LEAD + RASL + PRE + 1; i++) begin
      @(posedge clk); @(negedge clk);
      g_c = 1'b0; g_r = 1'b0;
      chk("R5 cas_n", cas_c, int'(i > LEAD + RASL));
      chk("R5 ras_n", ras_c, int'(!(i > LEAD && i <= LEAD + RASL)));
      chk("R7 active cbr", act_c, int'(i <= LEAD + RASL + PRE));
      chk("R6 cas_n", cas_r, 1);
      chk("R6 ras_n", ras_r, int'(i > RASL));
      chk("R7 active ro", act_r, int'(i <= RASL + PRE));
      chk("R7 we_n", we_c & we_r, 1);
    end
    chk("R9 backlog cbr", bl_c, MAXB - 1);
    chk("R9 backlog ro", bl_r, MAXB - 1);
    chk("R8 row after one", row_r, 1);
    g_c = 1'b1; g_r = 1'b1;
    k = 1; prev_ras = 1; prev_bl = bl_c; prev_act = act_c;
    for (int j = 0; j < 12 * TICK; j++) begin
      @(posedge clk); @(negedge clk);
      if (!prev_act && prev_bl != 0) chk("R4 start on grant", act_c, 1);
      if (bl_c == 0) chk("R4 grant ignored", act_c | int'(!ras_c), 0);
      chk("R8 cbr row", row_c, 0);
      if (!ras_r && prev_ras) begin
        chk("R8 row wrap", row_r, k % (1 << ROWB));
        k++;
      end
      prev_ras = ras_r; prev_bl = bl_c; prev_act = act_c;
    end
    chk("R8 wrap covered", int'(k > (1 << ROWB)), 1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule